// File: doc/BRIEF.md
# Prescaled One-Shot Countdown Timer

This block counts down a programmed value at a rate derived from a slow base tick. A single-cycle enable, `base_tick`, marks each edge of the base clock in the fast bus clock domain. A prescaler divides that tick stream by a power of two between 1 and 128, and each divided period takes one off the count. Software writes a divide code and a start count through a small register port. It can read the remaining count back at any time, and `expire` pulses when the count runs out.

The timer runs once per start. A new start count replaces any countdown in progress. A start count of zero stops the timer. The block moves no data stream, so the register port is plain strobes with no handshake. A write takes effect at the next clock edge. Read data is combinational from `rd_addr` and always valid. Register addresses are 0 (divide code, read/write), 1 (start count, read/write), 2 (remaining count, read only) and 3 (unused).

Top module: `countdown_timer`

## Requirements
- R1: The divide index is {code[3], code[1:0]} of the divide register. Bit 2 has no effect. The ratio is 2 to the power ((index + 1) mod 8), so index 0 divides by 2 and index 7 divides by 1. Address 0 reads back code bits 3:0, with all higher bits 0.
- R2: If a start write lands in a cycle without `base_tick`, the first later tick only aligns the prescaler. Counting starts with the tick after it. If the write lands in a tick cycle, that tick does the aligning. After alignment, expiry comes on the (count × ratio)-th tick.
- R3: A write to address 1 loads the countdown at once and replaces any countdown in progress. Address 1 reads back the written value.
- R4: Address 2 reads the number of divided periods not yet fully elapsed. A period that is partly elapsed counts as a whole one, so the value is remaining ticks divided by the ratio, rounded up.
- R5: Address 2 is read only. A write to it leaves the countdown and every read value unchanged.
- R6: `expire` is high for exactly one clock. It rises at the edge where the remaining count becomes 0, once per countdown.
- R7: A start count of 0 stops the timer. No expiry follows, and address 2 reads 0.
- R8: After reset, and whenever the timer is idle or has expired, address 2 reads 0. Reset clears every register and `expire`.
- R9: Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle pulse per base clock edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write register select |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read register select |
| rd_data | output | DATA_W | Combinational read data |
| expire | output | 1 | One-cycle pulse when the count reaches 0 |

## Verification
A wrong prescaler phase or a missed alignment tick shows up on address 2 within one divided period, as a value one above or below the rounded-up count. It also shifts the `expire` edge by at least one base tick. A wrong decode of the divide code changes the count of ticks between decrements, which shows up on the first period after a start. A countdown that survives a reload or a zero write shows as an extra `expire` pulse or a non-zero read of address 2. These effects can be seen from the cycle after the faulty edge.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  localparam int MAX_SHIFT = 7;
  localparam int PH_W      = MAX_SHIFT;

  localparam logic [1:0] ADDR_DIVCFG = 2'd0;
  localparam logic [1:0] ADDR_START  = 2'd1;
  localparam logic [1:0] ADDR_REMAIN = 2'd2;

  // Index wraps modulo 8 through the 3-bit add.
  function automatic logic [2:0] code_to_shift(input logic [3:0] code);
    return {code[3], code[1:0]} + 3'd1;
  endfunction
endpackage

// File: rtl/div_decode.sv
`timescale 1ns/1ps
module div_decode
  import timer_pkg::*;
(
  input  logic [3:0]      code,
  output logic [PH_W-1:0] limit
);
  logic [2:0]    shift;
  logic [PH_W:0] ratio;

  always_comb begin
    shift = code_to_shift(code);
    ratio = (PH_W+1)'(1) << shift;
    limit = PH_W'(ratio - (PH_W+1)'(1));
  end
endmodule

// File: rtl/prescaler.sv
`timescale 1ns/1ps
module prescaler
  import timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            tick,
  input  logic            run,
  input  logic [PH_W-1:0] limit,
  output logic            period_done
);
  logic            aligned_q;
  logic [PH_W-1:0] phase_q;

  assign period_done = run && tick && aligned_q && (phase_q >= limit) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned_q <= 1'b0;
      phase_q   <= '0;
    end else if (load) begin
      phase_q   <= '0;
      aligned_q <= tick;
    end else if (run && tick) begin
      if (!aligned_q)           aligned_q <= 1'b1;
      else if (phase_q >= limit) phase_q  <= '0;
      else                       phase_q  <= phase_q + PH_W'(1);
    end
  end
endmodule

// File: rtl/down_counter.sv
`timescale 1ns/1ps
module down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      expire  <= 1'b0;
    end else if (load) begin
      count_q <= load_val;
      expire  <= 1'b0;
    end else if (step) begin
      count_q <= count_q - CNT_W'(1);
      expire  <= (count_q == CNT_W'(1));
    end else begin
      expire  <= 1'b0;
    end
  end
endmodule

// File: rtl/countdown_timer.sv
`timescale 1ns/1ps
module countdown_timer
  import timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              expire
);
  logic [3:0]       cfg_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] count_q;
  logic [PH_W-1:0]  limit;
  logic             load;
  logic             period_done;
  logic             running;

  assign load    = wr_en && (wr_addr == ADDR_W'(ADDR_START));
  assign running = (count_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      start_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_DIVCFG)) cfg_q   <= wr_data[3:0];
      if (load)                            start_q <= wr_data[CNT_W-1:0];
    end
  end

  div_decode u_dec (
    .code  (cfg_q),
    .limit (limit)
  );

  prescaler u_pre (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .tick        (base_tick),
    .run         (running),
    .limit       (limit),
    .period_done (period_done)
  );

  down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (wr_data[CNT_W-1:0]),
    .step     (period_done),
    .count_q  (count_q),
    .expire   (expire)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADDR_DIVCFG))      rd_data = DATA_W'(cfg_q);
    else if (rd_addr == ADDR_W'(ADDR_START))  rd_data = DATA_W'(start_q);
    else if (rd_addr == ADDR_W'(ADDR_REMAIN)) rd_data = DATA_W'(count_q);
  end
endmodule

// File: rtl/timer_chk.sv
`timescale 1ns/1ps
module timer_chk
  import timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  count_q,
  input logic              expire
);
  logic is_load;
  assign is_load = wr_en && (wr_addr == ADDR_W'(ADDR_START));

  AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R6
  AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (count_q == '0)); // R6
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |=> (count_q == $past(wr_data[CNT_W-1:0]))); // R3
  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && wr_data[CNT_W-1:0] == '0) |=> (count_q == '0 && !expire)); // R7
  AST_STEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !is_load |=> (count_q == $past(count_q) || count_q == $past(count_q) - CNT_W'(1))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !is_load) |=> (count_q == '0 && !expire)); // R8
endmodule

bind countdown_timer timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .count_q (count_q),
  .expire  (expire)
);

// File: tb/countdown_timer_bench.sv
`timescale 1ns/1ps
module countdown_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        expire;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int tick_gap = 2;
  int tcnt = 0;
  int rot = 0;
  int pin = -1;
  bit done = 0;

  // behavioural reference: remaining base ticks until expiry
  longint m_left = 0;
  bit     m_align = 0;
  bit     m_exp = 0;
  logic [3:0]  m_cfg = '0;
  logic [31:0] m_init = '0;

  always #5 clk = ~clk;

  countdown_timer u_countdown_timer (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .expire(expire)
  );

  function automatic longint ratio(input logic [3:0] c);
    int idx = {c[3], c[1:0]};
    return longint'(1) << ((idx + 1) % 8);
  endfunction

  function automatic longint exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return longint'(m_cfg);
      2'd1: return longint'(m_init);
      2'd2: return (m_left + ratio(m_cfg) - 1) / ratio(m_cfg);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_align = 0; m_exp = 0; m_cfg = '0; m_init = '0;
    end else begin
      m_exp = 0;
      if (wr_en && wr_addr == 2'd1) begin
        m_init  = wr_data;
        m_left  = longint'(wr_data) * ratio(m_cfg);
        m_align = !base_tick;
      end else if (base_tick && m_left > 0) begin
        if (m_align) m_align = 0;
        else begin
          m_left = m_left - 1;
          if (m_left == 0) m_exp = 1;
        end
      end
      if (wr_en && wr_addr == 2'd0) m_cfg = wr_data[3:0];
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic compare();
    string t;
    case (rd_addr)
      2'd0: t = "R1"; 2'd1: t = "R3"; 2'd2: t = "R4"; default: t = "R9";
    endcase
    chk(longint'(rd_data) == exp_rd(rd_addr), t, longint'(rd_data), exp_rd(rd_addr));
    chk(expire == m_exp, "R2 R6 expire", longint'(expire), longint'(m_exp));
    if (expire) pulses++;
  endtask

  task automatic cycle(input bit we, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    compare();
    wr_en = we; wr_addr = a; wr_data = d;
    base_tick = ((tcnt % tick_gap) == 0);
    tcnt++;
    rd_addr = (pin >= 0) ? 2'(pin) : 2'(rot % 4);
    rot++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle(0, 2'd0, 32'd0);
  endtask

  task automatic run_to_expire(input int maxc);
    int p0 = pulses;
    for (int i = 0; i < maxc && pulses == p0; i++) cycle(0, 2'd0, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // reset state
    for (int a = 0; a < 4; a++) begin
      pin = a; cycle(0, 2'd0, 32'd0); #1;
      chk(rd_data == 32'd0, "R8 reset read", longint'(rd_data), 0);
    end
    @(negedge clk); rst_n = 1'b1; pin = -1;
    run(4);
    chk(expire == 1'b0, "R8 reset expire", longint'(expire), 0);

    // every divide code, bit 2 and high bits varied
    for (int c = 0; c < 16; c++) begin
      tick_gap = 2;
      cycle(1, 2'd0, 32'hFFFF_FFF0 | 32'(c));
      pin = 0; cycle(0, 2'd0, 32'd0); #1;
      chk(rd_data == 32'(c), "R1 code readback", longint'(rd_data), c);
      pin = -1;
      pulses = 0;
      cycle(1, 2'd1, 32'd3);
      run_to_expire(3 * 128 * 2 + 20);
      chk(pulses == 1, "R6 one pulse", pulses, 1);
      run(3);
      pin = 2; cycle(0, 2'd0, 32'd0); #1;
      chk(rd_data == 32'd0, "R8 after expiry", longint'(rd_data), 0);
      pin = -1;
    end

    // write in a tick cycle, ticks every cycle, divide by 2
    tick_gap = 1;
    cycle(1, 2'd0, 32'd0);
    pulses = 0;
    cycle(1, 2'd1, 32'd5);
    run_to_expire(100);
    chk(pulses == 1, "R2 aligned on tick", pulses, 1);

    // reload in progress, divide by 4, sparse ticks
    tick_gap = 3;
    cycle(1, 2'd0, 32'd1);
    pulses = 0;
    cycle(1, 2'd1, 32'd10);
    run(20);
    cycle(1, 2'd1, 32'd2);
    run_to_expire(200);
    run(40);
    chk(pulses == 1, "R3 reload replaces", pulses, 1);

    // write to read-only remaining count
    tick_gap = 1;
    cycle(1, 2'd1, 32'd20);
    run(10);
    pin = 2;
    cycle(1, 2'd2, 32'd999);
    cycle(0, 2'd0, 32'd0); #1;
    chk(longint'(rd_data) == exp_rd(2'd2) && rd_data != 32'd999, "R5 read only",
        longint'(rd_data), exp_rd(2'd2));
    pin = -1;
    run_to_expire(200);

    // zero start stops the timer
    pulses = 0;
    cycle(1, 2'd1, 32'd10);
    run(7);
    cycle(1, 2'd1, 32'd0);
    run(200);
    chk(pulses == 0, "R7 no expiry", pulses, 0);
    pin = 2; cycle(0, 2'd0, 32'd0); #1;
    chk(rd_data == 32'd0, "R7 stopped read", longint'(rd_data), 0);
    pin = 3; cycle(0, 2'd0, 32'd0); #1;
    chk(rd_data == 32'd0, "R9 unused addr", longint'(rd_data), 0);
    pin = -1;
    run(4);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule